// File: doc/BRIEF.md
# Multi-Grant Interrupt Source Aggregator

This block gathers a set of level-sensitive interrupt sources and turns them into a single interrupt request towards a processor, together with the vector code of the source to serve first. A source is not switched on by one mask bit. Each source keeps a counter of enable grants. Every mask field, priority field or group that covers the source adds one grant when it enables the source, and removes one when it disables it. The source counts as enabled only while its counter equals the number of grants it needs. That number is a per-source configuration input: the count of fields and groups that name the source.

A source is pending when its input level is asserted and it is fully enabled. A running count of pending sources moves up by one when a source becomes pending and down by one when a source stops. The processor request line is high exactly while that count is nonzero. Vector lookup scans the sources from index 0 upward and reports the code of the first one that is pending. It reports nothing when the processor's interrupt mask level is 0xF. Register decoding, which turns bus writes into grant strobes, and comparison of priorities between sources are left to neighbouring logic.

Top module: `irq_enable_aggregator`

## Requirements
- R1: A source is pending exactly when its registered level is high and its grant counter equals its required count `need_cnt`, a required count of 0 included. Pending flags and all dependent outputs reflect source and strobe inputs two clock edges after they are applied.
- R2: The level input is sampled every cycle. A rising level asserts the source, a falling level removes the assertion, and a level held unchanged for many cycles leaves the pending count unchanged.
- R3: `pend_count` rises by one when a source becomes pending and falls by one when a source stops being pending, so it always equals the number of set bits in `src_pending`. It is wide enough to hold NUM_SRC.
- R4: `cpu_irq` is high exactly while `pend_count` is nonzero. The interrupt mask does not affect it.
- R5: When `imask` is 4'hF, `vec_valid` is low one edge later, whatever is pending.
- R6: Otherwise `vec_out` is the code of the lowest-index pending source. Source i's code is field `vec_code[i*VEC_W +: VEC_W]`, and `vec_valid` is high.
- R7: A grant increment strobe and a grant decrement strobe for the same source in the same cycle leave its counter unchanged.
- R8: A grant counter does not go below 0, and it does not go above the required count: extra increments are ignored.
- R9: After synchronous reset, and whenever no source is pending, `vec_valid`, `cpu_irq`, `pend_count` and `src_pending` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Interrupt level per source |
| grant_inc | input | NUM_SRC | One-cycle enable grant strobe per source |
| grant_dec | input | NUM_SRC | One-cycle enable withdrawal strobe per source |
| need_cnt | input | NUM_SRC*GNT_W | Required grant count per source, field i at i*GNT_W |
| vec_code | input | NUM_SRC*VEC_W | Vector code per source, field i at i*VEC_W |
| imask | input | 4 | Processor interrupt mask level |
| src_pending | output | NUM_SRC | Pending flag per source |
| pend_count | output | $clog2(NUM_SRC+1) | Number of pending sources |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_out | output | VEC_W | Vector code of the lowest-index pending source |
| vec_valid | output | 1 | `vec_out` is meaningful |

## Verification
Two things can land in one cycle: a grant increment and a grant decrement for the same source. A source can also gain and lose pending status in the same cycle that another source changes. The bench pulses both strobes on one source together, once with the source already enabled and once with it not enabled. It then checks that the pending state is the same as before the pulse. It also changes the levels of several sources in one cycle, and checks the pending count, the request line and the chosen vector against a model of the requirements.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Width needed to count from 0 up to n inclusive.
  function automatic int count_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
  localparam logic [3:0] IMASK_BLOCK_ALL = 4'hF;
endpackage

// File: rtl/irq_src_slice.sv
module irq_src_slice #(
  parameter int GNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  input  logic             inc,
  input  logic             dec,
  input  logic [GNT_W-1:0] need,
  output logic             pend_now
);
  logic             asserted_q;
  logic [GNT_W-1:0] grants_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      asserted_q <= 1'b0;
      grants_q   <= '0;
    end else begin
      asserted_q <= level;
      // opposite strobes cancel; counter clamps at 0 and at need
      if (inc && !dec && (grants_q < need))
        grants_q <= grants_q + 1'b1;
      else if (dec && !inc && (grants_q != '0))
        grants_q <= grants_q - 1'b1;
    end
  end

  assign pend_now = asserted_q && (grants_q == need);
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker #(
  parameter int NUM_SRC = 8,
  localparam int PC_W = irq_agg_pkg::count_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_now,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [PC_W-1:0]    count_q,
  output logic               irq_q
);
  localparam logic [PC_W-1:0] ONE = 1;
  logic [PC_W-1:0] rises, falls, count_next;

  always_comb begin
    rises = '0;
    falls = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_now[i] && !pend_q[i]) rises = rises + ONE;
      if (!pend_now[i] && pend_q[i]) falls = falls + ONE;
    end
    count_next = count_q + rises - falls;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= pend_now;
      count_q <= count_next;
      irq_q   <= (count_next != '0);
    end
  end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       pend_now,
  input  logic [NUM_SRC*VEC_W-1:0] codes,
  input  logic [3:0]               imask,
  output logic [VEC_W-1:0]         vec_q,
  output logic                     valid_q
);
  logic             hit;
  logic [VEC_W-1:0] pick;

  // descending walk so the lowest pending index is written last
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_now[i]) begin
        hit  = 1'b1;
        pick = codes[i*VEC_W +: VEC_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      vec_q   <= pick;
      valid_q <= hit && (imask != irq_agg_pkg::IMASK_BLOCK_ALL);
    end
  end
endmodule

// File: rtl/irq_enable_aggregator.sv
module irq_enable_aggregator #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  parameter int GNT_W   = 3,
  localparam int PC_W   = irq_agg_pkg::count_width(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       src_level,
  input  logic [NUM_SRC-1:0]       grant_inc,
  input  logic [NUM_SRC-1:0]       grant_dec,
  input  logic [NUM_SRC*GNT_W-1:0] need_cnt,
  input  logic [NUM_SRC*VEC_W-1:0] vec_code,
  input  logic [3:0]               imask,
  output logic [NUM_SRC-1:0]       src_pending,
  output logic [PC_W-1:0]          pend_count,
  output logic                     cpu_irq,
  output logic [VEC_W-1:0]         vec_out,
  output logic                     vec_valid
);
  logic [NUM_SRC-1:0] pend_now;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_slice #(.GNT_W(GNT_W)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .level    (src_level[g]),
      .inc      (grant_inc[g]),
      .dec      (grant_dec[g]),
      .need     (need_cnt[g*GNT_W +: GNT_W]),
      .pend_now (pend_now[g])
    );
  end

  irq_pend_tracker #(.NUM_SRC(NUM_SRC)) u_track (
    .clk      (clk),
    .rst      (rst),
    .pend_now (pend_now),
    .pend_q   (src_pending),
    .count_q  (pend_count),
    .irq_q    (cpu_irq)
  );

  irq_vec_select #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vec (
    .clk      (clk),
    .rst      (rst),
    .pend_now (pend_now),
    .codes    (vec_code),
    .imask    (imask),
    .vec_q    (vec_out),
    .valid_q  (vec_valid)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  localparam int PC_W   = irq_agg_pkg::count_width(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_level,
  input logic [3:0]         imask,
  input logic [NUM_SRC-1:0] src_pending,
  input logic [PC_W-1:0]    pend_count,
  input logic               cpu_irq,
  input logic [VEC_W-1:0]   vec_out,
  input logic               vec_valid
);
  a_r3_count_matches: assert property (@(posedge clk) disable iff (rst)
    int'(pend_count) == $countones(src_pending));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(pend_count) <= NUM_SRC);

  a_r4_irq_follows_count: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (pend_count != '0));

  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (imask == 4'hF) |=> !vec_valid);

  a_r9_valid_needs_pending: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (src_pending != '0));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    // R1: a pending source had its level high two edges earlier
    a_r1_pend_needs_level: assert property (@(posedge clk) disable iff (rst)
      src_pending[g] |-> $past(src_level[g], 2));
  end
endmodule

bind irq_enable_aggregator irq_agg_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .src_level(src_level), .imask(imask),
  .src_pending(src_pending), .pend_count(pend_count), .cpu_irq(cpu_irq),
  .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/tb_irq_enable_aggregator.sv
module tb_irq_enable_aggregator;
  localparam int N = 8, VW = 8, GW = 3;
  localparam int PCW = irq_agg_pkg::count_width(N);

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_level = '0, grant_inc = '0, grant_dec = '0;
  logic [N*GW-1:0] need_cnt;
  logic [N*VW-1:0] vec_code;
  logic [3:0] imask = 4'h0;
  logic [N-1:0] src_pending;
  logic [PCW-1:0] pend_count;
  logic cpu_irq, vec_valid;
  logic [VW-1:0] vec_out;

  int tests = 0, fails = 0;
  int m_grant [N];
  int m_need  [N];
  logic [N-1:0] m_lvl = '0;

  always #2 clk = ~clk;  // 250 MHz

  irq_enable_aggregator #(.NUM_SRC(N), .VEC_W(VW), .GNT_W(GW)) dut (
    .clk(clk), .rst(rst), .src_level(src_level), .grant_inc(grant_inc),
    .grant_dec(grant_dec), .need_cnt(need_cnt), .vec_code(vec_code),
    .imask(imask), .src_pending(src_pending), .pend_count(pend_count),
    .cpu_irq(cpu_irq), .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // compare all outputs against the requirement model
  task automatic check_all(input string req);
    logic [N-1:0] ep;
    int cnt, first;
    cnt = 0; first = -1;
    for (int i = 0; i < N; i++) begin
      ep[i] = m_lvl[i] && (m_grant[i] == m_need[i]);
      if (ep[i]) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    chk({req, " pending"}, int'(src_pending), int'(ep));
    chk({req, " count R3"}, int'(pend_count), cnt);
    chk({req, " irq R4"}, int'(cpu_irq), int'(cnt != 0));
    chk({req, " valid R5/R9"}, int'(vec_valid), int'(cnt != 0 && imask != 4'hF));
    if (cnt != 0) chk({req, " vector R6"}, int'(vec_out), 8'h80 + first * 8);
  endtask

  task automatic strobe(input logic [N-1:0] inc, input logic [N-1:0] dec);
    grant_inc = inc; grant_dec = dec;
    for (int i = 0; i < N; i++) begin
      if (inc[i] && !dec[i] && m_grant[i] < m_need[i]) m_grant[i]++;
      else if (dec[i] && !inc[i] && m_grant[i] > 0) m_grant[i]--;
    end
    @(negedge clk);
    grant_inc = '0; grant_dec = '0;
  endtask

  task automatic set_level(input logic [N-1:0] lv);
    src_level = lv; m_lvl = lv;
    @(negedge clk);
  endtask

  task automatic t_reset();
    settle();
    check_all("R9 reset");
  endtask

  task automatic t_enable_basic();
    set_level(8'b0000_1000);
    settle(); check_all("R1 asserted but no grant");
    strobe(8'b0000_1000, '0);
    settle(); check_all("R1 fully granted");
    repeat (10) @(negedge clk);
    check_all("R2 held level");
  endtask

  task automatic t_priority();
    strobe(8'b0000_0010, '0);
    set_level(8'b0000_1010);
    settle(); check_all("R6 lower index wins");
    set_level(8'b0000_1000);
    settle(); check_all("R2 falling level");
  endtask

  task automatic t_mask();
    imask = 4'hF;
    settle(); check_all("R5 mask F");
    imask = 4'hE;
    settle(); check_all("R5 mask E");
  endtask

  task automatic t_cancel();
    strobe(8'b0000_1000, 8'b0000_1000);
    settle(); check_all("R7 cancel while enabled");
    set_level(8'b0001_1000);
    strobe(8'b0001_0000, 8'b0001_0000);
    settle(); check_all("R7 cancel while disabled");
  endtask

  task automatic t_saturate();
    set_level(8'b0001_1100);
    strobe(8'b0000_0100, '0);
    strobe(8'b0000_0100, '0);
    strobe(8'b0000_0100, '0);
    settle(); check_all("R8 extra grants");
    strobe('0, 8'b0000_0100);
    settle(); check_all("R8 upper clamp");
    strobe('0, 8'b0000_0100);
    strobe('0, 8'b0000_0100);
    strobe('0, 8'b0000_0100);
    strobe(8'b0000_0100, '0);
    strobe(8'b0000_0100, '0);
    settle(); check_all("R8 lower clamp");
  endtask

  task automatic t_zero_need();
    set_level(8'b0011_1110);
    settle(); check_all("R1 zero need");
    set_level(8'b1111_1111);
    strobe(8'b1100_0001, '0);
    settle(); check_all("R3 many pending");
    set_level('0);
    settle(); check_all("R9 all quiet");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_grant[i] = 0;
      m_need[i]  = (i == 2) ? 2 : (i == 5) ? 0 : 1;
      need_cnt[i*GW +: GW] = GW'(m_need[i]);
      vec_code[i*VW +: VW] = VW'(8'h80 + i * 8);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable_basic();
    t_priority();
    t_mask();
    t_cancel();
    t_saturate();
    t_zero_need();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule